// File: doc/BRIEF.md
# I2C Expander Power-Enable Sequencer

This block switches on a memory supply rail that is gated by pin 0 of an 8-bit I2C I/O expander. The expander's active-low reset pin is pulled low on the board, so the sequencer first releases that pin. It then waits a settling interval and issues a fixed list of register transactions on a req/ack transaction port. A byte-level I2C engine outside the block serves that port. The first transaction sets the output latch bit. The second turns pin 0 into an output. An optional third transaction reads the input port back to confirm the rail enable is high.

The sequence starts by itself when reset ends. When it finishes, the block raises a done flag. A NACK on any transaction, or a readback whose checked bits are wrong, raises a sticky error flag and stops all traffic. A synchronous restart input puts the expander back into reset and runs the whole sequence again from the start.

Top module: `pwr_rail_seq`

## Requirements
- R1: `exp_rst_n` is 0 while `rst_n` is low and in the cycle after a restart is sampled. It rises one cycle after the block leaves that state. `req` is never high while `exp_rst_n` is 0, and `req` first rises no earlier than SETTLE_CYC cycles after `exp_rst_n` rises.
- R2: The first transaction is a write (`req_rd`=0) with `req_addr`=0x42, `req_cmd`=0x01 and `req_wdata`=0x01.
- R3: The second transaction is a write with `req_addr`=0x42, `req_cmd`=0x03 and `req_wdata`=0xFE. Bit 0 becomes an output and bits 7..1 stay inputs.
- R4: With VERIFY_EN=1, the third transaction is a read (`req_rd`=1) with `req_addr`=0x43, `req_cmd`=0x00 and `req_wdata`=0x00.
- R5: The sequence starts after reset with no trigger input.
- R6: Once `req` rises, it stays high and `req_addr`, `req_cmd`, `req_wdata` and `req_rd` stay stable until `ack` is sampled high.
- R7: In the cycle after `ack` is sampled with `req` high, `req` is low. Every request is separated from the next by at least one low cycle.
- R8: An `ack` with `ack_nack`=1 sets `error`. No further requests are issued until a restart.
- R9: On the verify read, `ack_rdata` bit 0 equal to 0 sets `error`. Bit 0 equal to 1 sets `done`. Bits 7..1 have no effect (VERIFY_MASK=0x01).
- R10: A restart clears `done` and `error`, drives `exp_rst_n` low, and reruns the complete sequence from the first transaction, even when it arrives in the middle of a request.
- R11: `done` and `error` are never high together. Each stays high, with `req` low, until a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous rerun of the full sequence |
| exp_rst_n | output | 1 | Active-low reset to the expander |
| req | output | 1 | Transaction request |
| req_addr | output | 8 | 8-bit bus address (write 0x42, read 0x43) |
| req_cmd | output | 8 | Expander register (command byte) |
| req_wdata | output | 8 | Write data |
| req_rd | output | 1 | 1 = write command byte, repeated start, read one byte |
| ack | input | 1 | Transaction complete, one cycle |
| ack_nack | input | 1 | Transaction failed on a NACK, valid with ack |
| ack_rdata | input | 8 | Read byte, valid with ack |
| done | output | 1 | Rail enabled and verified |
| error | output | 1 | Sticky failure |

## Verification
The hardest cases to reach from the ports are a NACK on one chosen transaction of the series, and a restart that lands while a request is still waiting for its ack. The responder model in the bench answers each request after a random latency. It injects a NACK at a step chosen at random and returns a random readback byte, so error paths occur at every step and with every value of bits 7..1. A directed run watches the transaction log and pulses restart while the second request is pending. It then checks that the rerun begins again with the first write.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        ST_RST,
        ST_SETTLE,
        ST_REQ,
        ST_GAP,
        ST_DONE,
        ST_ERR
    } seq_state_t;

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] cmd;
        logic [7:0] wdata;
        logic       rd;
    } xact_t;

    localparam logic [6:0] EXP_ADDR7   = 7'h21;
    localparam logic [7:0] EXP_WR_ADDR = {EXP_ADDR7, 1'b0};
    localparam logic [7:0] EXP_RD_ADDR = {EXP_ADDR7, 1'b1};

    localparam logic [7:0] REG_INPUT  = 8'h00;
    localparam logic [7:0] REG_OUTPUT = 8'h01;
    localparam logic [7:0] REG_CONFIG = 8'h03;

endpackage

// File: rtl/pwr_seq_step.sv
module pwr_seq_step
    import pwr_seq_pkg::*;
#(
    parameter bit         VERIFY_EN = 1'b1,
    parameter logic [7:0] RAIL_MASK = 8'h01
) (
    input  logic [1:0] step,
    output xact_t      xact,
    output logic       last
);

    localparam logic [1:0] LAST_STEP = VERIFY_EN ? 2'd2 : 2'd1;

    always_comb begin
        xact = '{addr: EXP_WR_ADDR, cmd: REG_OUTPUT, wdata: RAIL_MASK, rd: 1'b0};
        case (step)
            2'd1:    xact = '{addr: EXP_WR_ADDR, cmd: REG_CONFIG, wdata: ~RAIL_MASK, rd: 1'b0};
            2'd2:    xact = '{addr: EXP_RD_ADDR, cmd: REG_INPUT,  wdata: 8'h00,      rd: 1'b1};
            default: ;
        endcase
        last = (step == LAST_STEP);
    end

endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
    parameter int CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int CNT_W = (CYC > 1) ? $clog2(CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run && cnt_q != CNT_END) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = run && (cnt_q == CNT_END);

endmodule

// File: rtl/pwr_rail_seq.sv
module pwr_rail_seq
    import pwr_seq_pkg::*;
#(
    parameter int         SETTLE_CYC  = 4,
    parameter bit         VERIFY_EN   = 1'b1,
    parameter logic [7:0] VERIFY_MASK = 8'h01
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    output logic       exp_rst_n,
    output logic       req,
    output logic [7:0] req_addr,
    output logic [7:0] req_cmd,
    output logic [7:0] req_wdata,
    output logic       req_rd,
    input  logic       ack,
    input  logic       ack_nack,
    input  logic [7:0] ack_rdata,
    output logic       done,
    output logic       error
);

    typedef struct packed {
        seq_state_t st;
        logic [1:0] step;
    } seq_t;

    seq_t  s_d, s_q;
    xact_t xact;
    logic  last_step;
    logic  settle_done;
    logic  verify_ok;

    pwr_seq_step #(
        .VERIFY_EN (VERIFY_EN),
        .RAIL_MASK (VERIFY_MASK)
    ) u_step (
        .step (s_q.step),
        .xact (xact),
        .last (last_step)
    );

    pwr_seq_timer #(
        .CYC (SETTLE_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (s_q.st == ST_SETTLE),
        .expired (settle_done)
    );

    assign verify_ok = (ack_rdata & VERIFY_MASK) == VERIFY_MASK;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_RST: begin
                s_d.st   = ST_SETTLE;
                s_d.step = '0;
            end
            ST_SETTLE: begin
                if (settle_done) s_d.st = ST_REQ;
            end
            ST_REQ: begin
                if (ack) begin
                    if (ack_nack) begin
                        s_d.st = ST_ERR;
                    end else if (xact.rd && !verify_ok) begin
                        s_d.st = ST_ERR;
                    end else if (last_step) begin
                        s_d.st = ST_DONE;
                    end else begin
                        s_d.st   = ST_GAP;
                        s_d.step = s_q.step + 2'd1;
                    end
                end
            end
            ST_GAP:  s_d.st = ST_REQ;
            default: ;
        endcase
        if (restart) begin
            s_d.st   = ST_RST;
            s_d.step = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_RST, step: 2'd0};
        end else begin
            s_q <= s_d;
        end
    end

    assign exp_rst_n = (s_q.st != ST_RST);
    assign req       = (s_q.st == ST_REQ);
    assign req_addr  = xact.addr;
    assign req_cmd   = xact.cmd;
    assign req_wdata = xact.wdata;
    assign req_rd    = xact.rd;
    assign done      = (s_q.st == ST_DONE);
    assign error     = (s_q.st == ST_ERR);

endmodule

// File: rtl/pwr_rail_seq_chk.sv
module pwr_rail_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       restart,
    input logic       exp_rst_n,
    input logic       req,
    input logic [7:0] req_addr,
    input logic [7:0] req_cmd,
    input logic [7:0] req_wdata,
    input logic       req_rd,
    input logic       ack,
    input logic       done,
    input logic       error
);

    a_r1_no_traffic_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> exp_rst_n);

    a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        req && !ack && !restart |=> req && $stable(req_addr) && $stable(req_cmd)
                                   && $stable(req_wdata) && $stable(req_rd));

    a_r7_gap_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        req && ack |=> !req);

    a_r8_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        error && !restart |=> error && !req);

    a_r11_done_held: assert property (@(posedge clk) disable iff (!rst_n)
        done && !restart |=> done && !req);

    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    a_r10_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !exp_rst_n && !done && !error && !req);

    a_r4_read_addr: assert property (@(posedge clk) disable iff (!rst_n)
        req && req_rd |-> req_addr == 8'h43 && req_cmd == 8'h00);

endmodule

bind pwr_rail_seq pwr_rail_seq_chk u_chk (.*);

// File: tb/pwr_rail_seq_test.sv
module pwr_rail_seq_test;

    localparam int SETTLE = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       restart = 1'b0;
    logic       exp_rst_n, req, req_rd, done, error;
    logic [7:0] req_addr, req_cmd, req_wdata;
    logic       ack = 1'b0;
    logic       ack_nack = 1'b0;
    logic [7:0] ack_rdata = 8'h00;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // responder control and transaction log
    int         nack_at = -1;
    logic [7:0] rd_val = 8'h01;
    int         n_tx = 0;
    logic [7:0] log_addr [8];
    logic [7:0] log_cmd  [8];
    logic [7:0] log_wd   [8];
    logic       log_rd   [8];

    // protocol monitors
    int  hold_bad = 0;
    int  gap_bad = 0;
    int  early_bad = 0;
    int  settle_bad = 0;
    int  rel_cnt = 0;
    bit  seen_req = 0;
    bit  prev_acked = 0;

    always #4 clk = ~clk;

    pwr_rail_seq #(.SETTLE_CYC(SETTLE)) uut (
        .clk(clk), .rst_n(rst_n), .restart(restart), .exp_rst_n(exp_rst_n),
        .req(req), .req_addr(req_addr), .req_cmd(req_cmd), .req_wdata(req_wdata),
        .req_rd(req_rd), .ack(ack), .ack_nack(ack_nack), .ack_rdata(ack_rdata),
        .done(done), .error(error)
    );

    function automatic logic [7:0] x_addr(int i);
        return (i == 2) ? 8'h43 : 8'h42;
    endfunction
    function automatic logic [7:0] x_cmd(int i);
        return (i == 0) ? 8'h01 : (i == 1) ? 8'h03 : 8'h00;
    endfunction
    function automatic logic [7:0] x_wd(int i);
        return (i == 0) ? 8'h01 : (i == 1) ? 8'hFE : 8'h00;
    endfunction

    task automatic check(bit ok, string req_tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
        end
    endtask

    // responder: answers each request after a random latency
    initial begin
        forever begin
            @(negedge clk);
            ack = 1'b0;
            ack_nack = 1'b0;
            if (req && rst_n && !restart) begin
                int idx = n_tx;
                if (n_tx < 8) begin
                    log_addr[n_tx] = req_addr;
                    log_cmd[n_tx]  = req_cmd;
                    log_wd[n_tx]   = req_wdata;
                    log_rd[n_tx]   = req_rd;
                end
                n_tx++;
                repeat ($urandom_range(0, 3)) @(negedge clk);
                ack = 1'b1;
                ack_nack = (idx == nack_at);
                ack_rdata = rd_val;
                @(negedge clk);
                ack = 1'b0;
                ack_nack = 1'b0;
            end
        end
    end

    // monitors sampled on the falling edge
    logic [7:0] p_addr, p_cmd, p_wd;
    logic       p_rd, p_req;
    initial begin
        p_req = 0; p_addr = 0; p_cmd = 0; p_wd = 0; p_rd = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (req && !exp_rst_n) early_bad++;
                if (!exp_rst_n) begin
                    rel_cnt = 0;
                    seen_req = 0;
                end else if (!seen_req) begin
                    if (req) begin
                        if (rel_cnt < SETTLE) settle_bad++;
                        seen_req = 1;
                    end else begin
                        rel_cnt++;
                    end
                end
                if (prev_acked && req) gap_bad++;
                if (p_req && req && !prev_acked && !restart &&
                    (req_addr != p_addr || req_cmd != p_cmd || req_wd_ne(p_wd) || req_rd != p_rd))
                    hold_bad++;
            end
            prev_acked = req && ack;
            p_req = req && !restart; p_addr = req_addr; p_cmd = req_cmd;
            p_wd = req_wdata; p_rd = req_rd;
        end
    end

    function automatic bit req_wd_ne(logic [7:0] w);
        return req_wdata != w;
    endfunction

    task automatic pulse_restart();
        @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        n_tx = 0;
        check(exp_rst_n == 1'b0 && !done && !error, "R10 restart state",
              {exp_rst_n, done, error}, 0);
    endtask

    // runs one full sequence and checks log and outcome
    task automatic run_case(int nk, logic [7:0] rv, bit first);
        int exp_tx;
        bit exp_err;
        int wait_c = 0;
        nack_at = nk;
        rd_val = rv;
        if (!first) pulse_restart();
        if (nk >= 0 && nk < 3) begin
            exp_tx = nk + 1; exp_err = 1;
        end else begin
            exp_tx = 3; exp_err = !rv[0];
        end
        while (!done && !error && wait_c < 400) begin
            @(negedge clk);
            wait_c++;
        end
        check(n_tx == exp_tx, "R5 R8 transaction count", n_tx, exp_tx);
        for (int i = 0; i < exp_tx && i < n_tx; i++) begin
            check(log_addr[i] == x_addr(i) && log_cmd[i] == x_cmd(i) &&
                  log_wd[i] == x_wd(i) && log_rd[i] == (i == 2),
                  (i == 0) ? "R2 first write" : (i == 1) ? "R3 second write" : "R4 verify read",
                  {log_addr[i], log_cmd[i], log_wd[i]}, {x_addr(i), x_cmd(i), x_wd(i)});
        end
        check(error == exp_err && done == !exp_err, exp_err ? "R8 R9 error outcome" : "R9 done outcome",
              {done, error}, {!exp_err, exp_err});
        repeat (20) @(negedge clk);
        check(n_tx == exp_tx && error == exp_err && done == !exp_err,
              "R11 outcome held, no traffic", n_tx, exp_tx);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check(exp_rst_n == 0 && req == 0 && done == 0 && error == 0, "R1 reset state",
              {exp_rst_n, req, done, error}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(exp_rst_n == 1'b1, "R1 expander reset released", exp_rst_n, 1);

        run_case(-1, 8'h01, 1);     // directed: only bit 0 set
        run_case(-1, 8'hFE, 0);     // directed R9: bit 0 clear, others set
        run_case(0, 8'h01, 0);      // directed R8: nack on first write
        run_case(-1, 8'hFF, 0);

        // directed R10: restart while second request pending
        nack_at = -1;
        rd_val = 8'h01;
        pulse_restart();
        while (n_tx < 2) @(negedge clk);
        pulse_restart();
        begin
            int wc = 0;
            while (!done && !error && wc < 400) begin
                @(negedge clk);
                wc++;
            end
        end
        check(n_tx == 3 && done && log_cmd[0] == 8'h01, "R10 rerun from first step",
              n_tx, 3);

        for (int k = 0; k < 20; k++) begin
            int nk = $urandom_range(0, 5);
            run_case((nk < 3) ? nk : -1, 8'($urandom), 0);
        end

        check(early_bad == 0, "R1 no request while expander in reset", early_bad, 0);
        check(settle_bad == 0, "R1 settle interval", settle_bad, 0);
        check(hold_bad == 0, "R6 request held stable", hold_bad, 0);
        check(gap_bad == 0, "R7 idle cycle between requests", gap_bad, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule